// File: doc/BRIEF.md
# Cascaded Quadrature Position Counter with Capture

This block keeps a 32-bit position as two 16-bit counter halves. The low half counts one of two sources. In tick mode it counts a single-cycle count-enable. In phase mode it counts a two-phase quadrature encoder. The high half has no count source of its own. It steps up by one when the low half wraps from all-ones to zero, and steps down by one when the low half wraps from zero to all-ones.

Two capture pins take a consistent snapshot of the position. An edge on the first pin stores the high half, and an edge on the second pin stores the low half. When both pins fire in the same cycle, the two registers together hold the full 32-bit value, taken before that cycle's count update. A single edge-select field applies to both pins. A write port loads either counter half directly.

Top module: `cascade_qcnt`

## Requirements
- R1: While rst_ni is low, both counter halves and both capture registers read zero.
- R2: With mode_i = 0, the low half increments by one on each clock where tick_i is 1. Phase pin activity has no effect on the counters.
- R3: With mode_i = 1, every single-phase transition counts by one. Taking {phase_a_i, phase_b_i}, the sequence 00, 10, 11, 01, 00 (A leads) counts up, and the reverse order (B leads) counts down. tick_i is ignored in this mode.
- R4: In phase mode, a step where both phases change together leaves the count unchanged.
- R5: A low-half wrap from 0xFFFF to 0x0000 increments the high half by one. The high half does not change unless there is a wrap or a write to it.
- R6: A low-half wrap from 0x0000 to 0xFFFF decrements the high half by one.
- R7: When wr_en_i is 1, wr_data_i loads the low half (wr_hi_i = 0) or the high half (wr_hi_i = 1). The write overrides counting in that cycle. A write to the low half never carries into the high half.
- R8: A selected edge on cap_a_i loads cap_hi_o with the high half, and a selected edge on cap_b_i loads cap_lo_o with the low half. Both take the values held before that cycle's count update. Each pin affects only its own register.
- R9: cap_edge_i selects the capture edge: 00 rising, 01 falling, 10 both edges, 11 capture disabled.
- R10: Encoder and capture pins pass through a two-flop synchronizer. A pin change applied between clock edges shows up in the counters or capture registers just after the third following rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 1 | 0 = tick counting, 1 = phase counting |
| tick_i | input | 1 | Synchronous count enable for tick mode |
| phase_a_i | input | 1 | Encoder phase A |
| phase_b_i | input | 1 | Encoder phase B |
| cap_a_i | input | 1 | Capture pin for the high half |
| cap_b_i | input | 1 | Capture pin for the low half |
| cap_edge_i | input | 2 | Capture edge select |
| wr_en_i | input | 1 | Counter write strobe |
| wr_hi_i | input | 1 | Write target: 0 low half, 1 high half |
| wr_data_i | input | 16 | Write data |
| cnt_lo_o | output | 16 | Low counter half |
| cnt_hi_o | output | 16 | High counter half |
| cap_hi_o | output | 16 | Capture register holding the high half |
| cap_lo_o | output | 16 | Capture register holding the low half |

## Verification
Ticks and writes act at the next rising edge, so the bench drives them at a falling edge and samples at the falling edge that follows. Phase and capture pins pass through two synchronizer flops and one edge-history flop before they reach the counters or capture registers. The bench therefore holds each pin change and samples three falling edges later. The R10 check also confirms that nothing has changed after only two edges. Carry and capture collisions are lined up by placing a tick in the exact cycle in which the synchronized capture edge arrives.

// File: rtl/cascade_qcnt_pkg.sv
package cascade_qcnt_pkg;
  localparam int unsigned HALF_W = 16;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } cap_edge_e;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_prev_o
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[s] <= '0;
      else         stg[s] <= stg[s-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_prev_o <= '0;
    else         q_prev_o <= stg[STAGES-1];
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/quad_step.sv
module quad_step (
  input  logic a_i,
  input  logic b_i,
  input  logic a_prev_i,
  input  logic b_prev_i,
  output logic step_o,
  output logic up_o
);
  logic a_chg, b_chg;
  assign a_chg  = a_i ^ a_prev_i;
  assign b_chg  = b_i ^ b_prev_i;
  // exactly one phase moved; double moves dropped
  assign step_o = a_chg ^ b_chg;
  assign up_o   = a_i ^ b_prev_i;
endmodule

// File: rtl/cnt_half.sv
module cnt_half #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] q_o,
  output logic         ovf_o,
  output logic         unf_o
);
  localparam logic [W-1:0] MAX = {W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (wr_i)  q_o <= wr_data_i;
    else if (inc_i) q_o <= q_o + 1'b1;
    else if (dec_i) q_o <= q_o - 1'b1;
  end

  assign ovf_o = inc_i & ~wr_i & (q_o == MAX);
  assign unf_o = dec_i & ~inc_i & ~wr_i & (q_o == '0);

  // R7
  wr_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> q_o == $past(wr_data_i));
endmodule

// File: rtl/cascade_qcnt.sv
module cascade_qcnt
  import cascade_qcnt_pkg::*;
#(
  parameter int unsigned W           = HALF_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         mode_i,
  input  logic         tick_i,
  input  logic         phase_a_i,
  input  logic         phase_b_i,
  input  logic         cap_a_i,
  input  logic         cap_b_i,
  input  logic [1:0]   cap_edge_i,
  input  logic         wr_en_i,
  input  logic         wr_hi_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] cnt_lo_o,
  output logic [W-1:0] cnt_hi_o,
  output logic [W-1:0] cap_hi_o,
  output logic [W-1:0] cap_lo_o
);
  localparam int unsigned NPIN = 4;

  logic [NPIN-1:0] syn, syn_d;
  logic step, up;
  logic lo_inc, lo_dec, lo_ovf, lo_unf;
  logic lo_wr, hi_wr;
  logic cap_a_ev, cap_b_ev;
  cap_edge_e esel;

  pin_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .d_i      ({cap_b_i, cap_a_i, phase_b_i, phase_a_i}),
    .q_o      (syn),
    .q_prev_o (syn_d)
  );

  quad_step u_quad (
    .a_i      (syn[0]),
    .b_i      (syn[1]),
    .a_prev_i (syn_d[0]),
    .b_prev_i (syn_d[1]),
    .step_o   (step),
    .up_o     (up)
  );

  assign lo_inc = mode_i ? (step & up) : tick_i;
  assign lo_dec = mode_i & step & ~up;
  assign lo_wr  = wr_en_i & ~wr_hi_i;
  assign hi_wr  = wr_en_i & wr_hi_i;

  cnt_half #(.W(W)) u_lo (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (lo_wr),
    .wr_data_i (wr_data_i),
    .inc_i     (lo_inc),
    .dec_i     (lo_dec),
    .q_o       (cnt_lo_o),
    .ovf_o     (lo_ovf),
    .unf_o     (lo_unf)
  );

  cnt_half #(.W(W)) u_hi (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (hi_wr),
    .wr_data_i (wr_data_i),
    .inc_i     (lo_ovf),
    .dec_i     (lo_unf),
    .q_o       (cnt_hi_o),
    .ovf_o     (),
    .unf_o     ()
  );

  // capture edge qualification
  assign esel = cap_edge_e'(cap_edge_i);

  function automatic logic edge_hit(input cap_edge_e sel, input logic cur, input logic prv);
    case (sel)
      EDGE_RISE: edge_hit = cur & ~prv;
      EDGE_FALL: edge_hit = ~cur & prv;
      EDGE_BOTH: edge_hit = cur ^ prv;
      default:   edge_hit = 1'b0;
    endcase
  endfunction

  assign cap_a_ev = edge_hit(esel, syn[2], syn_d[2]);
  assign cap_b_ev = edge_hit(esel, syn[3], syn_d[3]);

  // snapshot pre-update values so a carry cannot tear the pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_hi_o <= '0;
      cap_lo_o <= '0;
    end else begin
      if (cap_a_ev) cap_hi_o <= cnt_hi_o;
      if (cap_b_ev) cap_lo_o <= cnt_lo_o;
    end
  end

  // R5
  hi_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_ovf && !hi_wr) |=> cnt_hi_o == W'($past(cnt_hi_o) + 1'b1));

  // R6
  hi_borrow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lo_unf && !hi_wr) |=> cnt_hi_o == W'($past(cnt_hi_o) - 1'b1));

  // R5
  hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lo_ovf && !lo_unf && !hi_wr) |=> $stable(cnt_hi_o));

  // R4
  dbl_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i && (syn[0] != syn_d[0]) && (syn[1] != syn_d[1]) && !lo_wr)
      |=> $stable(cnt_lo_o));

  // R8
  cap_snap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_a_ev |=> cap_hi_o == $past(cnt_hi_o));

  // R9
  cap_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_edge_i == 2'b11) |=> ($stable(cap_hi_o) && $stable(cap_lo_o)));
endmodule

// File: tb/tb_cascade_qcnt.sv
module tb_cascade_qcnt;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        mode_i, tick_i, phase_a_i, phase_b_i, cap_a_i, cap_b_i;
  logic [1:0]  cap_edge_i;
  logic        wr_en_i, wr_hi_i;
  logic [15:0] wr_data_i;
  logic [15:0] cnt_lo_o, cnt_hi_o, cap_hi_o, cap_lo_o;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk_i = ~clk_i;

  cascade_qcnt dut (.*);

  // {a, b, expected lo, expected hi}; starts from lo=FFFE hi=0005 phases 00
  localparam logic [33:0] VEC [11] = '{
    {2'b10, 16'hFFFF, 16'h0005},
    {2'b11, 16'h0000, 16'h0006},
    {2'b01, 16'h0001, 16'h0006},
    {2'b00, 16'h0002, 16'h0006},
    {2'b01, 16'h0001, 16'h0006},
    {2'b11, 16'h0000, 16'h0006},
    {2'b10, 16'hFFFF, 16'h0005},
    {2'b00, 16'hFFFE, 16'h0005},
    {2'b11, 16'hFFFE, 16'h0005},
    {2'b01, 16'hFFFF, 16'h0005},
    {2'b00, 16'h0000, 16'h0006}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(input logic hi, input logic [15:0] d);
    wr_en_i = 1'b1; wr_hi_i = hi; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic tick1();
    tick_i = 1'b1;
    @(negedge clk_i);
    tick_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; mode_i = 1'b0; tick_i = 1'b0;
    phase_a_i = 1'b0; phase_b_i = 1'b0; cap_a_i = 1'b0; cap_b_i = 1'b0;
    cap_edge_i = 2'b00; wr_en_i = 1'b0; wr_hi_i = 1'b0; wr_data_i = '0;
    wait_n(3);
    chk("R1 lo", cnt_lo_o, 16'h0);
    chk("R1 hi", cnt_hi_o, 16'h0);
    chk("R1 cap_hi", cap_hi_o, 16'h0);
    chk("R1 cap_lo", cap_lo_o, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 tick counting and phase pins ignored
    tick1();
    chk("R2 tick", cnt_lo_o, 16'h0001);
    phase_a_i = 1'b1; wait_n(4);
    phase_a_i = 1'b0; wait_n(4);
    chk("R2 phase ignored", cnt_lo_o, 16'h0001);

    // R5 overflow carry
    wr(1'b0, 16'hFFFF);
    tick1();
    chk("R5 lo wrap", cnt_lo_o, 16'h0000);
    chk("R5 hi inc", cnt_hi_o, 16'h0001);

    // R7 write beats tick, no carry
    wr(1'b0, 16'hFFFF);
    tick_i = 1'b1;
    wr(1'b0, 16'h0005);
    tick_i = 1'b0;
    chk("R7 write prio", cnt_lo_o, 16'h0005);
    chk("R7 no carry", cnt_hi_o, 16'h0001);
    wr(1'b1, 16'h0005);
    chk("R7 hi write", cnt_hi_o, 16'h0005);

    // R3 tick ignored in phase mode
    mode_i = 1'b1;
    tick1();
    chk("R3 tick ignored", cnt_lo_o, 16'h0005);

    // R3 R4 R5 R6 vector walk
    wr(1'b0, 16'hFFFE);
    for (int i = 0; i < 11; i++) begin
      {phase_a_i, phase_b_i} = VEC[i][33:32];
      wait_n(3);
      chk("R3/R4/R5/R6 vec lo", cnt_lo_o, VEC[i][31:16]);
      chk("R3/R4/R5/R6 vec hi", cnt_hi_o, VEC[i][15:0]);
    end

    // R10 latency
    phase_a_i = 1'b1;
    wait_n(2);
    chk("R10 not yet", cnt_lo_o, 16'h0000);
    wait_n(1);
    chk("R10 due", cnt_lo_o, 16'h0001);

    // R8 simultaneous capture with carry in the capture cycle
    mode_i = 1'b0;
    wr(1'b0, 16'hFFFF);
    wr(1'b1, 16'h0000);
    cap_a_i = 1'b1; cap_b_i = 1'b1;
    wait_n(2);
    tick1();
    chk("R8 cap_hi pre", cap_hi_o, 16'h0000);
    chk("R8 cap_lo pre", cap_lo_o, 16'hFFFF);
    chk("R5 carry at capture", cnt_hi_o, 16'h0001);

    // R9 falling only, single pin
    cap_edge_i = 2'b01;
    wr(1'b0, 16'h03A2);
    wr(1'b1, 16'h0007);
    cap_a_i = 1'b0; wait_n(3);
    chk("R9 fall cap_hi", cap_hi_o, 16'h0007);
    chk("R8 other pin untouched", cap_lo_o, 16'hFFFF);
    wr(1'b1, 16'h0009);
    cap_a_i = 1'b1; wait_n(3);
    chk("R9 rise ignored", cap_hi_o, 16'h0007);

    // R9 disabled
    cap_edge_i = 2'b11;
    cap_a_i = 1'b0; cap_b_i = 1'b0; wait_n(3);
    chk("R9 off hi", cap_hi_o, 16'h0007);
    chk("R9 off lo", cap_lo_o, 16'hFFFF);

    // R9 both edges
    cap_edge_i = 2'b10;
    cap_b_i = 1'b1; wait_n(3);
    chk("R9 both rise", cap_lo_o, 16'h03A2);
    wr(1'b0, 16'h0044);
    cap_b_i = 1'b0; wait_n(3);
    chk("R9 both fall", cap_lo_o, 16'h0044);
    chk("R8 hi untouched", cap_hi_o, 16'h0007);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule